// File: doc/BRIEF.md
# Accelerometer Sample Output Formatter

This block turns one signed acceleration sample per axis into the two-byte word that a host reads for that axis. Each sample is a 13-bit two's-complement value at 4 mg per LSB. A small configuration set selects the measurement range (±2 g, ±4 g, ±8 g or ±16 g). It also selects between a fixed-scale mode that gains output bits as the range widens and a 10-bit mode that trades scale for range. A third setting picks left or right alignment inside the 16-bit word. A separate bit sets the active level of the interrupt pins.

The formatted words for X, Y and Z are held in live registers, which are refreshed whenever a new sample set is presented. The host reads them byte by byte. A read of byte address 0 starts a burst and copies all six bytes into a shadow copy. The remaining bytes of that burst come from the shadow copy, so a sample that lands mid-burst cannot tear the result. Raw interrupt events from elsewhere pass through a polarity stage before they reach the pins.

Top module: `accfmt_top`

## Requirements
- R1: With full resolution on, the output width is 10 plus the range code (2 g=0, 4 g=1, 8 g=2, 16 g=3). The sample value is kept unscaled and saturated to that width.
- R2: With full resolution off, the sample is arithmetically shifted right by the range code and saturated to 10 bits.
- R3: With the justify setting at 1, the result's MSB sits at bit 15 and the bits below the result are zero. At 0, the result is right-aligned and sign-extended to 16 bits.
- R4: Byte addresses 0 to 5 return, in order, X low, X high, Y low, Y high, Z low, Z high. The low byte is bits 7:0 and the high byte is bits 15:8. Read data appears on the cycle after the read strobe and holds while no read is made.
- R5: A read of address 0 copies all six live bytes into the shadow copy. Reads of addresses 1 to 5 return the shadow copy, and a sample arriving between them does not change what they return.
- R6: A configuration change alters nothing already captured. It applies from the next sample onward.
- R7: Each interrupt pin equals its event when the invert bit is 0, and the complement of its event when the invert bit is 1.
- R8: After reset, the read data and every live and shadow byte are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| sample_valid_i | input | 1 | New sample set present on the sample inputs |
| sample_x_i | input | 13 | X sample, signed, 4 mg/LSB |
| sample_y_i | input | 13 | Y sample, signed, 4 mg/LSB |
| sample_z_i | input | 13 | Z sample, signed, 4 mg/LSB |
| cfg_range_i | input | 2 | Range code: 0=±2 g, 1=±4 g, 2=±8 g, 3=±16 g |
| cfg_full_res_i | input | 1 | 1: width grows with range at fixed scale; 0: 10-bit output |
| cfg_justify_i | input | 1 | 1: left-aligned; 0: right-aligned, sign-extended |
| cfg_int_inv_i | input | 1 | 1: interrupt pins active low |
| rd_en_i | input | 1 | Host byte read strobe |
| rd_addr_i | input | 3 | Byte address 0..5 |
| rd_data_o | output | 8 | Byte read result, one cycle after the strobe |
| int_evt_i | input | 2 | Raw interrupt events, active high |
| int_pin_o | output | 2 | Interrupt pins after polarity |

## Verification
The bench drives extreme samples (+4095, -4096, -1, small odd negatives) through every range in both modes. A formatter that skipped saturation would wrap +4095 to a negative word. One that shifted logically instead of arithmetically would turn -3 into a large positive value. Left alignment at each width is compared bit for bit, which catches an alignment shift that ignores the range. Samples and configuration changes are placed between the start of a burst and its later bytes. A design that read from the live registers or reformatted on a configuration change would return mixed or re-scaled bytes.

// File: rtl/accfmt_pkg.sv
package accfmt_pkg;
    localparam int OUT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int NUM_AXES = 3;

    typedef enum logic [1:0] {
        RANGE_2G  = 2'd0,
        RANGE_4G  = 2'd1,
        RANGE_8G  = 2'd2,
        RANGE_16G = 2'd3
    } range_e;
endpackage

// File: rtl/accfmt_axis.sv
module accfmt_axis
    import accfmt_pkg::*;
#(
    parameter int SAMPLE_W = 13,
    parameter int BASE_W   = 10
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  range_e                     range_i,
    input  logic                       full_res_i,
    input  logic                       justify_i,
    output logic [OUT_W-1:0]           word_o
);
    int shift_n;
    int width_n;
    int value;
    int hi_lim;
    int lo_lim;
    logic [OUT_W-1:0] aligned;

    always_comb begin
        // 10-bit mode trades scale for range; full resolution keeps 4 mg/LSB
        shift_n = full_res_i ? 0 : int'(range_i);
        width_n = full_res_i ? BASE_W + int'(range_i) : BASE_W;
        value   = int'(sample_i) >>> shift_n;
        hi_lim  = (1 <<< (width_n - 1)) - 1;
        lo_lim  = -hi_lim - 1;
        if (value > hi_lim) begin
            value = hi_lim;
        end else if (value < lo_lim) begin
            value = lo_lim;
        end
        aligned = value[OUT_W-1:0];
        if (justify_i) begin
            aligned = aligned << (OUT_W - width_n);
        end
        word_o = aligned;
    end
endmodule

// File: rtl/accfmt_readout.sv
module accfmt_readout
    import accfmt_pkg::*;
#(
    parameter int NAX    = 3,
    parameter int ADDR_W = $clog2(2 * NAX)
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          sample_valid_i,
    input  logic [NAX-1:0][OUT_W-1:0]     word_i,
    input  logic                          rd_en_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    output logic [BYTE_W-1:0]             rd_data_o,
    output logic [NAX-1:0][OUT_W-1:0]     live_o,
    output logic [NAX-1:0][OUT_W-1:0]     shadow_o
);
    localparam int NBYTES = 2 * NAX;

    typedef struct packed {
        logic [NAX-1:0][OUT_W-1:0] live;
        logic [NAX-1:0][OUT_W-1:0] shadow;
        logic [BYTE_W-1:0]         rd_data;
    } state_t;

    state_t st_d;
    state_t st_q;
    logic [NAX-1:0][OUT_W-1:0] src_d;

    always_comb begin
        st_d  = st_q;
        src_d = st_q.shadow;
        if (sample_valid_i) begin
            st_d.live = word_i;
        end
        if (rd_en_i) begin
            if (rd_addr_i == '0) begin
                // burst start: freeze the whole sample set
                st_d.shadow = st_q.live;
                src_d       = st_q.live;
            end
            st_d.rd_data = '0;
            for (int a = 0; a < NAX; a++) begin
                if ((int'(rd_addr_i) >> 1) == a && int'(rd_addr_i) < NBYTES) begin
                    st_d.rd_data = rd_addr_i[0] ? src_d[a][BYTE_W +: BYTE_W]
                                                : src_d[a][0 +: BYTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rd_data;
    assign live_o    = st_q.live;
    assign shadow_o  = st_q.shadow;
endmodule

// File: rtl/accfmt_irq.sv
module accfmt_irq #(
    parameter int NUM_INT = 2
) (
    input  logic               invert_i,
    input  logic [NUM_INT-1:0] evt_i,
    output logic [NUM_INT-1:0] pin_o
);
    for (genvar i = 0; i < NUM_INT; i++) begin : g_pin
        assign pin_o[i] = invert_i ? ~evt_i[i] : evt_i[i];
    end
endmodule

// File: rtl/accfmt_top.sv
module accfmt_top
    import accfmt_pkg::*;
#(
    parameter int SAMPLE_W = 13,
    parameter int BASE_W   = 10,
    parameter int NUM_INT  = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       sample_valid_i,
    input  logic signed [SAMPLE_W-1:0] sample_x_i,
    input  logic signed [SAMPLE_W-1:0] sample_y_i,
    input  logic signed [SAMPLE_W-1:0] sample_z_i,
    input  logic [1:0]                 cfg_range_i,
    input  logic                       cfg_full_res_i,
    input  logic                       cfg_justify_i,
    input  logic                       cfg_int_inv_i,
    input  logic                       rd_en_i,
    input  logic [2:0]                 rd_addr_i,
    output logic [7:0]                 rd_data_o,
    input  logic [NUM_INT-1:0]         int_evt_i,
    output logic [NUM_INT-1:0]         int_pin_o
);
    localparam int NAX = NUM_AXES;

    logic signed [SAMPLE_W-1:0]  sample_arr [NAX];
    logic [NAX-1:0][OUT_W-1:0]   word_w;
    logic [NAX-1:0][OUT_W-1:0]   live_w;
    logic [NAX-1:0][OUT_W-1:0]   shadow_w;

    assign sample_arr[0] = sample_x_i;
    assign sample_arr[1] = sample_y_i;
    assign sample_arr[2] = sample_z_i;

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        accfmt_axis #(
            .SAMPLE_W (SAMPLE_W),
            .BASE_W   (BASE_W)
        ) u_axis (
            .sample_i   (sample_arr[a]),
            .range_i    (range_e'(cfg_range_i)),
            .full_res_i (cfg_full_res_i),
            .justify_i  (cfg_justify_i),
            .word_o     (word_w[a])
        );
    end

    accfmt_readout #(
        .NAX    (NAX),
        .ADDR_W (3)
    ) u_readout (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .sample_valid_i (sample_valid_i),
        .word_i         (word_w),
        .rd_en_i        (rd_en_i),
        .rd_addr_i      (rd_addr_i),
        .rd_data_o      (rd_data_o),
        .live_o         (live_w),
        .shadow_o       (shadow_w)
    );

    accfmt_irq #(
        .NUM_INT (NUM_INT)
    ) u_irq (
        .invert_i (cfg_int_inv_i),
        .evt_i    (int_evt_i),
        .pin_o    (int_pin_o)
    );
endmodule

// File: rtl/accfmt_chk.sv
module accfmt_chk #(
    parameter int NAX     = 3,
    parameter int W       = 16,
    parameter int NUM_INT = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_valid,
    input logic               full_res,
    input logic               justify,
    input logic               int_inv,
    input logic               rd_en,
    input logic [2:0]         rd_addr,
    input logic [7:0]         rd_data,
    input logic [NAX*W-1:0]   live,
    input logic [NAX*W-1:0]   shadow,
    input logic [NUM_INT-1:0] int_evt,
    input logic [NUM_INT-1:0] int_pin
);
    // R7
    irq_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_pin == (int_evt ^ {NUM_INT{int_inv}}));

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr == 3'd0) |=> $stable(shadow));

    // R5
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 3'd0) |=> shadow == $past(live));

    // R6
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(live));

    // R3
    left_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && justify && !full_res) |=> live[5:0] == 6'd0);
endmodule

bind accfmt_top accfmt_chk #(
    .NAX     (3),
    .W       (16),
    .NUM_INT (NUM_INT)
) u_chk (
    .clk          (clk_i),
    .rst_n        (rst_ni),
    .sample_valid (sample_valid_i),
    .full_res     (cfg_full_res_i),
    .justify      (cfg_justify_i),
    .int_inv      (cfg_int_inv_i),
    .rd_en        (rd_en_i),
    .rd_addr      (rd_addr_i),
    .rd_data      (rd_data_o),
    .live         (live_w),
    .shadow       (shadow_w),
    .int_evt      (int_evt_i),
    .int_pin      (int_pin_o)
);

// File: tb/accfmt_top_test.sv
module accfmt_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sv = 1'b0;
    logic signed [12:0] sx = '0, sy = '0, sz = '0;
    logic [1:0] rng = '0;
    logic fr = 1'b0, jst = 1'b0, inv = 1'b0;
    logic rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] evt = '0;
    logic [1:0] pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] got [6];

    always #2 clk = ~clk;

    accfmt_top uut (
        .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sv),
        .sample_x_i(sx), .sample_y_i(sy), .sample_z_i(sz),
        .cfg_range_i(rng), .cfg_full_res_i(fr), .cfg_justify_i(jst),
        .cfg_int_inv_i(inv), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .int_evt_i(evt), .int_pin_o(pin)
    );

    function automatic logic [15:0] model(int s, int r, bit f, bit j);
        int w;
        int v;
        int hi;
        logic [15:0] o;
        w  = f ? 10 + r : 10;
        v  = f ? s : (s >>> r);
        hi = (1 <<< (w - 1)) - 1;
        if (v > hi) v = hi;
        if (v < -hi - 1) v = -hi - 1;
        o = v[15:0];
        if (j) o = o << (16 - w);
        return o;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(int x, int y, int z);
        sx = 13'(x); sy = 13'(y); sz = 13'(z); sv = 1'b1;
        @(negedge clk);
        sv = 1'b0;
    endtask

    task automatic read_byte(int a);
        rd_en = 1'b1; rd_addr = 3'(a);
        @(negedge clk);
        rd_en = 1'b0;
        got[a] = rd_data;
    endtask

    task automatic burst();
        for (int a = 0; a < 6; a++) read_byte(a);
    endtask

    task automatic check_burst(string req, int x, int y, int z, int r, bit f, bit j);
        logic [15:0] e [3];
        e[0] = model(x, r, f, j);
        e[1] = model(y, r, f, j);
        e[2] = model(z, r, f, j);
        for (int a = 0; a < 3; a++) begin
            check(req, {got[2*a+1], got[2*a]}, e[a]);
        end
    endtask

    task automatic set_cfg(int r, bit f, bit j);
        rng = 2'(r); fr = f; jst = j;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 rd_data", {8'h0, rd_data}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        burst();
        for (int a = 0; a < 6; a++) check("R8 byte", {8'h0, got[a]}, 16'h0);

        // R1 full resolution saturation at 2 g
        set_cfg(0, 1, 0);
        push(4095, -4096, -1);
        burst();
        check("R1 sat+", {got[1], got[0]}, 16'h01FF);
        check("R1 sat-", {got[3], got[2]}, 16'hFE00);
        check("R1 neg1", {got[5], got[4]}, 16'hFFFF);
        // R1 full width at 16 g
        set_cfg(3, 1, 0);
        push(4095, -4096, 1234);
        burst();
        check_burst("R1", 4095, -4096, 1234, 3, 1, 0);
        check("R1 16g max", {got[1], got[0]}, 16'h0FFF);

        // R2 10-bit mode shift and saturate
        set_cfg(1, 0, 0);
        push(4095, -4096, -3);
        burst();
        check("R2 sat+", {got[1], got[0]}, 16'h01FF);
        check("R2 sat-", {got[3], got[2]}, 16'hFE00);
        check("R2 arith", {got[5], got[4]}, 16'hFFFE);
        set_cfg(3, 0, 0);
        push(4095, -4096, 100);
        burst();
        check("R2 16g", {got[1], got[0]}, 16'h01FF);
        check("R2 16g neg", {got[3], got[2]}, 16'hFE00);
        check("R2 16g small", {got[5], got[4]}, 16'h000C);

        // R3 left alignment
        set_cfg(3, 1, 1);
        push(4095, -1, 0);
        burst();
        check("R3 left 13b", {got[1], got[0]}, 16'h7FF8);
        check("R3 left neg", {got[3], got[2]}, 16'hFFF8);
        set_cfg(0, 0, 1);
        push(-512, 511, 1);
        burst();
        check("R3 left 10b", {got[1], got[0]}, 16'h8000);
        check("R3 left 10b+", {got[3], got[2]}, 16'h7FC0);
        // R4 byte order of a directed pattern
        set_cfg(3, 1, 0);
        push(12'h123, 12'h456, 12'h789);
        burst();
        check("R4 xl", {8'h0, got[0]}, 16'h0023);
        check("R4 xh", {8'h0, got[1]}, 16'h0001);
        check("R4 yl", {8'h0, got[2]}, 16'h0056);
        check("R4 zh", {8'h0, got[5]}, 16'h0007);

        // R5 snapshot coherence across a mid-burst sample
        push(100, 200, 300);
        read_byte(0);
        push(-5, -6, -7);
        for (int a = 1; a < 6; a++) read_byte(a);
        check_burst("R5 coherent", 100, 200, 300, 3, 1, 0);
        burst();
        check_burst("R5 refresh", -5, -6, -7, 3, 1, 0);

        // R6 config change does not touch captured data
        set_cfg(0, 1, 0);
        push(1000, -1000, 50);
        set_cfg(2, 0, 1);
        burst();
        check_burst("R6 old cfg", 1000, -1000, 50, 0, 1, 0);
        push(1000, -1000, 50);
        burst();
        check_burst("R6 new cfg", 1000, -1000, 50, 2, 0, 1);

        // R1 R2 R3 R4 random mix
        for (int i = 0; i < 300; i++) begin
            int x, y, z, r;
            bit f, j;
            x = int'($urandom_range(0, 8191)) - 4096;
            y = int'($urandom_range(0, 8191)) - 4096;
            z = int'($urandom_range(0, 8191)) - 4096;
            r = int'($urandom_range(0, 3));
            f = 1'($urandom_range(0, 1));
            j = 1'($urandom_range(0, 1));
            set_cfg(r, f, j);
            push(x, y, z);
            burst();
            check_burst("R1 R2 R3 R4 random", x, y, z, r, f, j);
        end

        // R7 interrupt polarity
        for (int i = 0; i < 16; i++) begin
            evt = 2'($urandom_range(0, 3));
            inv = 1'(i % 2);
            #1;
            check("R7 pins", {14'h0, pin}, {14'h0, inv ? ~evt : evt});
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule